// File: doc/BRIEF.md
# Host Slave Register Access Port

This block is the host-side slave port of a network interface controller. A host processor uses it to read and write a bank of sixteen byte-wide internal registers. The host's chip select, read strobe and write strobe arrive with no relation to the controller's bus clock, so each one passes through a two-flop synchronizer before the port acts on it.

The host drives a 4-bit register number on the address lines. On a multiplexed address/data bus, an address-latch strobe can capture that number first. The port raises `ack` when the access is complete. It holds `ack` low for as long as the controller owns the local bus as master, so the host waits until mastership is released.

`ack` falls once the synchronized strobe is seen inactive. A held strobe therefore performs exactly one access. The arbitration logic that decides mastership sits outside this block and appears here only as the `master_act` input.

Top module: `host_slave_port`

## Requirements
- R1: After reset, `ack` is 0, `dout` is 0 and all sixteen registers read back as 0x00. A reset pulse later clears registers that were written.
- R2: An access starts when `cs_n` is 0 and `rd_n` or `wr_n` is 0, with `master_act` low. Inputs changed between clock edges make `ack` read 1 after the third rising edge and 0 after the second.
- R3: On a write, `din` (8 bits) is stored into register `addr` (4 bits, 0..15) at the same rising edge on which `ack` rises.
- R4: `dout` carries the selected register only while the synchronized chip select, the synchronized read strobe and `ack` are all active. At all other times `dout` is 0x00.
- R5: While `master_act` is 1, `ack` stays 0 and no access begins. `ack` rises at the first rising edge that samples `master_act` at 0 while a synchronized request is present.
- R6: After `cs_n` or the active strobe returns to 1, `ack` still reads 1 after the second rising edge and reads 0 after the third.
- R7: A strobe held active performs one access only. Changes on `din` or `addr` while `ack` is 1 modify no register.
- R8: A read or write strobe with `cs_n` at 1 is ignored: no `ack` and no register change.
- R9: When `ale` is 1 at a rising edge, the port latches `addr`. The next access uses that latched number rather than the address lines, and the latch is released when that access ends.
- R10: When `ale` has not been 1 since the last access, the port samples the address lines at the edge where the request is detected. Later changes on the address lines leave the register being read unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| ale | input | 1 | Address latch strobe, active high; tie to 0 for a non-multiplexed bus |
| addr | input | 4 | Register number |
| din | input | 8 | Write data from the host |
| master_act | input | 1 | Controller currently owns the local bus as master |
| ack | output | 1 | Access complete; the host waits while this is 0 |
| dout | output | 8 | Read data, 0x00 when not driving |

## Verification
Every result is due a fixed number of rising edges after the host changes its pins. `ack` and the write land on the third edge after a strobe begins, which is two synchronizer flops plus the state register. `ack` falls on the third edge after the strobe ends. `dout` follows `ack` in the same cycle. The bench changes inputs only at falling edges, counts the rising edges explicitly, and samples at the falling edge one edge before and just after each due edge, so both the early value and the new value are checked.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int HSP_AW = 4;
  localparam int HSP_DW = 8;

  typedef enum logic {HS_IDLE = 1'b0, HS_ACK = 1'b1} hs_state_e;

  // a host request is present when selected and either strobe is on
  function automatic logic host_req(input logic sel, input logic rd, input logic wr);
    return sel & (rd | wr);
  endfunction

  // address source: a latched address wins over the live lines
  function automatic logic [HSP_AW-1:0] pick_addr(input logic latched_ok,
                                                  input logic [HSP_AW-1:0] latched,
                                                  input logic [HSP_AW-1:0] live);
    return latched_ok ? latched : live;
  endfunction
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hsp_regfile.sv
module hsp_regfile #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] row [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                q <= '0;
        else if (we && (waddr == AW'(g)))          q <= wdata;
      end
      assign row[g] = q;
    end
  endgenerate

  assign rdata = row[raddr];
endmodule

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
  import hsp_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          rd_s,
  input  logic          wr_s,
  input  logic          master_act,
  input  logic          ale,
  input  logic [AW-1:0] addr,
  output logic          ack,
  output logic          start,
  output logic          wr_en,
  output logic [AW-1:0] sel_addr,
  output logic [AW-1:0] acc_addr
);
  hs_state_e     st;
  logic          req_s;
  logic          done;
  logic          ale_seen;
  logic [AW-1:0] lat_addr;

  assign req_s    = host_req(cs_s, rd_s, wr_s);
  assign start    = (st == HS_IDLE) && req_s && !master_act;
  assign done     = (st == HS_ACK) && !req_s;
  assign wr_en    = start && wr_s;
  assign sel_addr = pick_addr(ale_seen, lat_addr, addr);
  assign ack      = (st == HS_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= HS_IDLE;
    end else if (start) begin
      st <= HS_ACK;
    end else if (done) begin
      st <= HS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      ale_seen <= 1'b0;
    end else if (ale) begin
      lat_addr <= addr;
      ale_seen <= 1'b1;
    end else if (done) begin
      ale_seen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_addr <= '0;
    else if (start) acc_addr <= sel_addr;
  end
endmodule

// File: rtl/host_slave_port.sv
module host_slave_port
  import hsp_pkg::*;
#(
  parameter int AW          = HSP_AW,
  parameter int DW          = HSP_DW,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          ale,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          master_act,
  output logic          ack,
  output logic [DW-1:0] dout
);
  logic [2:0]    strobe_s;
  logic          cs_s, rd_s, wr_s;
  logic          req_s;
  logic          start, wr_en, rd_drive;
  logic [AW-1:0] sel_addr, acc_addr;
  logic [DW-1:0] rdata;

  hsp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({~cs_n, ~rd_n, ~wr_n}),
    .q     (strobe_s)
  );

  assign {cs_s, rd_s, wr_s} = strobe_s;
  assign req_s = host_req(cs_s, rd_s, wr_s);

  hsp_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .rd_s       (rd_s),
    .wr_s       (wr_s),
    .master_act (master_act),
    .ale        (ale),
    .addr       (addr),
    .ack        (ack),
    .start      (start),
    .wr_en      (wr_en),
    .sel_addr   (sel_addr),
    .acc_addr   (acc_addr)
  );

  hsp_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (sel_addr),
    .wdata (din),
    .raddr (acc_addr),
    .rdata (rdata)
  );

  assign rd_drive = ack && cs_s && rd_s;
  assign dout     = rd_drive ? rdata : '0;
endmodule

// File: rtl/hsp_chk.sv
module hsp_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic [DW-1:0] dout,
  input logic          master_act,
  input logic          cs_s,
  input logic          req_s,
  input logic          wr_en
);
  // R2
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> ($past(req_s) && !$past(master_act)));

  // R3
  wr_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ack);

  // R4
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (dout == '0));

  // R5
  master_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_act && !ack) |=> !ack);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req_s) |=> !ack);

  // R7
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !wr_en);

  // R8
  no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !ack) |=> !ack);
endmodule

bind host_slave_port hsp_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack        (ack),
  .dout       (dout),
  .master_act (master_act),
  .cs_s       (cs_s),
  .req_s      (req_s),
  .wr_en      (wr_en)
);

// File: tb/host_slave_port_test.sv
module host_slave_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic       master_act = 1'b0;
  logic       ack;
  logic [7:0] dout;

  int total = 0;
  int bad = 0;
  logic [7:0] model [16];

  // write vectors: {addr, data}
  localparam logic [11:0] VEC [8] = '{12'h0_00, 12'hF_FF, 12'h3_A5, 12'h7_5A,
                                      12'h2_81, 12'h1_18, 12'h3_C7, 12'hC_7E};

  host_slave_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ale(ale), .addr(addr), .din(din), .master_act(master_act),
    .ack(ack), .dout(dout)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_chk(input string req);
    edges(2);
    check(req, ack, 1);
    edges(1);
    check(req, ack, 0);
  endtask

  task automatic wr_cyc(input logic [3:0] a, input logic [7:0] d);
    addr = a; din = d; cs_n = 0; wr_n = 0;
    edges(2);
    check("R2 ack early", ack, 0);
    edges(1);
    check("R2 ack due", ack, 1);
    cs_n = 1; wr_n = 1;
    release_chk("R6 write release");
    model[a] = d;
  endtask

  task automatic rd_cyc(input logic [3:0] a, input string req);
    addr = a; cs_n = 0; rd_n = 0;
    edges(2);
    check("R4 dout before ack", dout, 0);
    edges(1);
    check(req, dout, model[a]);
    cs_n = 1; rd_n = 1;
    edges(3);
    check("R4 dout after release", dout, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    edges(3);
    rst_n = 1'b1;
    edges(1);
    // R1 reset state
    check("R1 ack", ack, 0);
    check("R1 dout", dout, 0);
    rd_cyc(4'd3, "R1 reset register");

    // R3 table walk: writes, then read back every register
    for (int v = 0; v < 8; v++) wr_cyc(VEC[v][11:8], VEC[v][7:0]);
    for (int a = 0; a < 16; a++) rd_cyc(4'(a), "R3 readback");

    // R5 master stall
    master_act = 1; addr = 4'd9; din = 8'h3C; cs_n = 0; wr_n = 0;
    edges(6);
    check("R5 stalled", ack, 0);
    master_act = 0;
    edges(1);
    check("R5 ack after release of master", ack, 1);
    cs_n = 1; wr_n = 1;
    release_chk("R6 after stall");
    model[9] = 8'h3C;
    rd_cyc(4'd9, "R5 stalled write landed");

    // R8 strobe without chip select
    addr = 4'd2; din = 8'hEE; wr_n = 0;
    edges(5);
    check("R8 no ack", ack, 0);
    wr_n = 1;
    edges(3);
    rd_cyc(4'd2, "R8 register untouched");

    // R7 held strobe: later din/addr changes ignored
    addr = 4'd4; din = 8'h11; cs_n = 0; wr_n = 0;
    edges(3);
    check("R7 ack", ack, 1);
    din = 8'h99; addr = 4'd7;
    edges(4);
    check("R7 ack held", ack, 1);
    cs_n = 1; wr_n = 1;
    edges(3);
    model[4] = 8'h11;
    rd_cyc(4'd4, "R7 first value kept");
    rd_cyc(4'd7, "R7 other register untouched");

    // R10 direct address sampled at detection; R6 release by chip select only
    addr = 4'd0; cs_n = 0; rd_n = 0;
    edges(3);
    check("R10 dout", dout, model[0]);
    addr = 4'd15;
    edges(2);
    check("R10 dout after addr change", dout, model[0]);
    cs_n = 1;
    release_chk("R6 chip select release");
    rd_n = 1;
    edges(3);

    // R9 latched address for a multiplexed bus
    ale = 1; addr = 4'd6;
    edges(1);
    ale = 0; addr = 4'd1; din = 8'hC3; cs_n = 0; wr_n = 0;
    edges(3);
    check("R9 ack", ack, 1);
    cs_n = 1; wr_n = 1;
    edges(3);
    model[6] = 8'hC3;
    rd_cyc(4'd6, "R9 latched address written");
    rd_cyc(4'd1, "R9 live address untouched");

    // R1 reset clears written registers
    rst_n = 0;
    edges(2);
    rst_n = 1;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    edges(1);
    rd_cyc(4'd15, "R1 cleared by reset");
    rd_cyc(4'd6, "R1 cleared by reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule